// File: doc/BRIEF.md
# Prioritized Interrupt Request Arbiter

The arbiter watches a bank of level-sensitive interrupt request lines, each with a small priority value that is programmed through a simple write port. Every cycle it picks the most urgent pending line. If the winner's priority is strictly above the processor's current priority, the arbiter offers it to the processor as a single request line plus a vector number. The vector is the index of the winning line.

Once an offer is made, it is frozen until the processor acknowledges it. A line that drops in the meantime does not cancel the offer: the processor still receives that line's vector. On acknowledge, the current-priority register takes the priority of the delivered line, so only strictly more urgent lines can interrupt afterwards. Lowering the current priority again is the job of surrounding logic and is not part of this block.

Top module: `prio_irq_arbiter`

## Requirements
- R1: After reset, `cpu_irq` is 0, `cur_prio` is 0 and every line's priority is 0, so a request line that is raised without any configuration is never offered.
- R2: When a line with a qualifying priority is first seen high at clock edge N, `cpu_irq` is 1 after edge N+2 and still 0 after edge N+1. This is three registered stages.
- R3: A line whose priority is 0 is never offered to the processor.
- R4: Among the pending lines, the one with the numerically largest priority wins, and `cpu_vec` equals its index (0 to NUM_SRC-1).
- R5: When several pending lines share the largest priority, the line with the lowest index wins.
- R6: An offer is made only if the winner's priority is strictly greater than `cur_prio`. An equal priority is not offered.
- R7: While `cpu_irq` is 1 and `cpu_ack` is 0, `cpu_irq` stays 1 and `cpu_vec` does not change, even if lines drop or more urgent lines arrive.
- R8: A line that is withdrawn after being offered and before acknowledge is still delivered with its own vector, and its priority is loaded into `cur_prio`.
- R9: An edge with `cpu_irq` and `cpu_ack` both 1 loads `cur_prio` with the delivered line's priority, and `cpu_irq` is 0 after that edge.
- R10: An edge with `cfg_we` = 1 stores `cfg_prio` as the priority of line `cfg_idx`. The next selection uses the new value.
- R11: `cpu_ack` has no effect while `cpu_irq` is 0, and `cur_prio` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| src_req | input | NUM_SRC | Level request lines, bit i is line i |
| cfg_we | input | 1 | Priority write strobe |
| cfg_idx | input | IDX_W | Line whose priority is written |
| cfg_prio | input | PRIO_W | Priority value to write |
| cpu_ack | input | 1 | Processor acknowledge of the current offer |
| cpu_irq | output | 1 | Request to the processor |
| cpu_vec | output | IDX_W | Index of the offered line |
| cur_prio | output | PRIO_W | Current-priority register |

## Verification
The bench withdraws an offered line and raises a more urgent one before acknowledge. A design that tracked the live winner would switch vectors or drop the request, and a design with a spurious path would not load the withdrawn line's priority. It times the first request to the exact edge, so an extra or missing pipeline stage shows up directly. It holds a line at a priority equal to `cur_prio` to catch a non-strict compare, sets up tied priorities to catch a highest-index tie break, and acknowledges while nothing is offered to catch a stray update of `cur_prio`.

// File: rtl/irq_arb_pkg.sv
// Package: shared types for the interrupt request arbiter.
// Assumes: nothing beyond IEEE 1800-2017.
package irq_arb_pkg;

    // Handshake state of the processor-side offer.
    typedef enum logic {
        OFFER_IDLE = 1'b0,
        OFFER_HELD = 1'b1
    } offer_state_e;

endpackage

// File: rtl/irq_prio_regs.sv
// Module: irq_prio_regs
// Holds one priority value per request line, written through a single
// strobe/index/data port. Assumes the index is in range when it matters;
// writes with an index beyond the last line are dropped.
module irq_prio_regs #(
    parameter int NUM_SRC = 16,
    parameter int PRIO_W  = 4,
    localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [PRIO_W-1:0] wr_val,
    output logic [PRIO_W-1:0] prio [NUM_SRC]
);

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_line
        // Per-line priority register, cleared by reset, loaded on a matching write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                prio[g] <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                prio[g] <= wr_val;
            end
        end
    end

    // R10: a write lands in the addressed line on the following cycle.
    a_r10_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (int'(wr_idx) < NUM_SRC)) |=> (prio[$past(wr_idx)] == $past(wr_val)));

endmodule

// File: rtl/irq_req_sample.sv
// Module: irq_req_sample
// First pipeline stage: registers the raw request lines once per cycle.
// Assumes the lines are synchronous to clk.
module irq_req_sample #(
    parameter int NUM_SRC = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] req_in,
    output logic [NUM_SRC-1:0] req_q
);

    // Capture every line each cycle; reset clears the captured set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= '0;
        end else begin
            req_q <= req_in;
        end
    end

endmodule

// File: rtl/irq_select.sv
// Module: irq_select
// Second pipeline stage: finds the pending line with the largest nonzero
// priority, with the lowest index winning ties, and registers the result.
// Assumes priorities are stable or change only through the config port.
module irq_select #(
    parameter int NUM_SRC = 16,
    parameter int PRIO_W  = 4,
    localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] req_q,
    input  logic [PRIO_W-1:0]  prio [NUM_SRC],
    output logic               sel_valid,
    output logic [IDX_W-1:0]   sel_idx,
    output logic [PRIO_W-1:0]  sel_prio
);

    logic [PRIO_W-1:0] best_prio;
    logic [IDX_W-1:0]  best_idx;

    // Scan from the top index down; ">=" lets a lower index take over a tie.
    always_comb begin
        best_prio = '0;
        best_idx  = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (req_q[i] && (prio[i] != '0) && (prio[i] >= best_prio)) begin
                best_prio = prio[i];
                best_idx  = IDX_W'(i);
            end
        end
    end

    // Register the winner so the compare stage sees a settled value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_valid <= 1'b0;
            sel_idx   <= '0;
            sel_prio  <= '0;
        end else begin
            sel_valid <= (best_prio != '0);
            sel_idx   <= best_idx;
            sel_prio  <= best_prio;
        end
    end

endmodule

// File: rtl/irq_commit.sv
// Module: irq_commit
// Third stage and handshake: offers the registered winner to the processor
// when it beats the current priority, freezes the offer until acknowledge,
// then loads the current priority. Assumes acknowledge is only meaningful
// while an offer is held; otherwise it is ignored.
module irq_commit
    import irq_arb_pkg::*;
#(
    parameter int NUM_SRC = 16,
    parameter int PRIO_W  = 4,
    localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_valid,
    input  logic [IDX_W-1:0]  sel_idx,
    input  logic [PRIO_W-1:0] sel_prio,
    input  logic              ack,
    output logic              irq_o,
    output logic [IDX_W-1:0]  vec_o,
    output logic [PRIO_W-1:0] cur_o
);

    offer_state_e      state_q;
    logic [IDX_W-1:0]  vec_q;
    logic [PRIO_W-1:0] prio_q;
    logic [PRIO_W-1:0] cur_q;
    logic              take;

    // A new offer is taken only from idle and only if strictly more urgent.
    always_comb begin
        take = (state_q == OFFER_IDLE) && sel_valid && (sel_prio > cur_q);
    end

    // Offer state, frozen vector/priority and the current-priority register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= OFFER_IDLE;
            vec_q   <= '0;
            prio_q  <= '0;
            cur_q   <= '0;
        end else begin
            case (state_q)
                OFFER_IDLE: begin
                    if (take) begin
                        state_q <= OFFER_HELD;
                        vec_q   <= sel_idx;
                        prio_q  <= sel_prio;
                    end
                end
                OFFER_HELD: begin
                    if (ack) begin
                        state_q <= OFFER_IDLE;
                        cur_q   <= prio_q;
                    end
                end
                default: state_q <= OFFER_IDLE;
            endcase
        end
    end

    // Drive the processor-side outputs from the held state.
    always_comb begin
        irq_o = (state_q == OFFER_HELD);
        vec_o = vec_q;
        cur_o = cur_q;
    end

    // R6: a fresh offer is always strictly above the current priority.
    a_r6_strictly_higher: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> (prio_q > cur_q));

    // R7: an unacknowledged offer persists with an unchanged vector.
    a_r7_offer_held: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !ack) |=> (irq_o && $stable(vec_o)));

    // R9: acknowledge withdraws the offer on the next cycle.
    a_r9_ack_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && ack) |=> !irq_o);

    // R9: acknowledge loads the delivered priority.
    a_r9_cur_loaded: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && ack) |=> (cur_o == $past(prio_q)));

    // R11: acknowledge with no offer leaves the current priority alone.
    a_r11_idle_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_o && ack) |=> $stable(cur_o));

endmodule

// File: rtl/prio_irq_arbiter.sv
// Module: prio_irq_arbiter (top)
// Three-stage prioritized interrupt arbiter: sample, select, commit.
// Assumes all inputs are synchronous to clk; reset is synchronous, active low.
module prio_irq_arbiter #(
    parameter int NUM_SRC = 16,
    parameter int PRIO_W  = 4,
    localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_req,
    input  logic               cfg_we,
    input  logic [IDX_W-1:0]   cfg_idx,
    input  logic [PRIO_W-1:0]  cfg_prio,
    input  logic               cpu_ack,
    output logic               cpu_irq,
    output logic [IDX_W-1:0]   cpu_vec,
    output logic [PRIO_W-1:0]  cur_prio
);

    logic [PRIO_W-1:0]  prio [NUM_SRC];
    logic [NUM_SRC-1:0] req_q;
    logic               sel_valid;
    logic [IDX_W-1:0]   sel_idx;
    logic [PRIO_W-1:0]  sel_prio;

    irq_prio_regs #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (cfg_we),
        .wr_idx (cfg_idx),
        .wr_val (cfg_prio),
        .prio   (prio)
    );

    irq_req_sample #(.NUM_SRC(NUM_SRC)) u_sample (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_in (src_req),
        .req_q  (req_q)
    );

    irq_select #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_select (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_q     (req_q),
        .prio      (prio),
        .sel_valid (sel_valid),
        .sel_idx   (sel_idx),
        .sel_prio  (sel_prio)
    );

    irq_commit #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_commit (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_valid (sel_valid),
        .sel_idx   (sel_idx),
        .sel_prio  (sel_prio),
        .ack       (cpu_ack),
        .irq_o     (cpu_irq),
        .vec_o     (cpu_vec),
        .cur_o     (cur_prio)
    );

endmodule

// File: tb/prio_irq_arbiter_test.sv
module prio_irq_arbiter_test;

    localparam int NUM_SRC = 16;
    localparam int PRIO_W  = 4;
    localparam int IDX_W   = 4;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [NUM_SRC-1:0] src_req = '0;
    logic               cfg_we = 1'b0;
    logic [IDX_W-1:0]   cfg_idx = '0;
    logic [PRIO_W-1:0]  cfg_prio = '0;
    logic               cpu_ack = 1'b0;
    logic               cpu_irq;
    logic [IDX_W-1:0]   cpu_vec;
    logic [PRIO_W-1:0]  cur_prio;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct { int vec; int prio; string tag; } exp_t;
    exp_t sb[$];
    bit   post_ack = 1'b0;
    exp_t last_exp;

    always #4 clk = ~clk;  // 125 MHz

    prio_irq_arbiter #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) uut (
        .clk(clk), .rst_n(rst_n), .src_req(src_req), .cfg_we(cfg_we),
        .cfg_idx(cfg_idx), .cfg_prio(cfg_prio), .cpu_ack(cpu_ack),
        .cpu_irq(cpu_irq), .cpu_vec(cpu_vec), .cur_prio(cur_prio)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; src_req = '0; cfg_we = 1'b0; cpu_ack = 1'b0;
        tick(); tick();
        rst_n = 1'b1;
        tick();
    endtask

    task automatic set_prio(input int idx, input int p);
        cfg_we = 1'b1; cfg_idx = IDX_W'(idx); cfg_prio = PRIO_W'(p);
        tick();
        cfg_we = 1'b0;
    endtask

    // Driver: waits for an offer, pushes the expectation, pulses acknowledge.
    task automatic ack_expect(input int vec, input int p, input string tag);
        exp_t e;
        int n = 0;
        while (!cpu_irq && n < 20) begin tick(); n++; end
        chk(cpu_irq == 1'b1, {tag, " offer present"}, cpu_irq, 1);
        e.vec = vec; e.prio = p; e.tag = tag;
        sb.push_back(e);
        cpu_ack = 1'b1;
        tick();
        cpu_ack = 1'b0;
        tick();
    endtask

    // Monitor: on each acknowledged offer pop and compare; next cycle check the load.
    always @(negedge clk) begin
        #1;
        if (rst_n) begin
            if (post_ack) begin
                post_ack = 1'b0;
                chk(cur_prio == PRIO_W'(last_exp.prio), {last_exp.tag, " R9 cur_prio load"},
                    cur_prio, last_exp.prio);
                chk(cpu_irq == 1'b0, {last_exp.tag, " R9 irq drop"}, cpu_irq, 0);
            end
            if (cpu_irq && cpu_ack) begin
                if (sb.size() == 0) begin
                    chk(1'b0, "R4 unexpected offer", cpu_vec, -1);
                end else begin
                    last_exp = sb.pop_front();
                    chk(cpu_vec == IDX_W'(last_exp.vec), {last_exp.tag, " vector"},
                        cpu_vec, last_exp.vec);
                    post_ack = 1'b1;
                end
            end
        end
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1: reset state
        chk(cpu_irq == 1'b0, "R1 irq after reset", cpu_irq, 0);
        chk(cur_prio == '0, "R1 cur_prio after reset", cur_prio, 0);
        // R1/R3: unconfigured (priority 0) line never offered
        src_req[5] = 1'b1;
        repeat (6) tick();
        chk(cpu_irq == 1'b0, "R3 priority-0 line offered", cpu_irq, 0);
        src_req = '0;
        tick();

        // R10 + R2: configure then time the first request
        set_prio(5, 3);
        src_req[5] = 1'b1;
        tick(); tick();
        chk(cpu_irq == 1'b0, "R2 irq too early", cpu_irq, 0);
        tick();
        chk(cpu_irq == 1'b1, "R2 irq after three edges", cpu_irq, 1);
        chk(cpu_vec == 4'd5, "R10 configured line vector", cpu_vec, 5);
        ack_expect(5, 3, "R9 line5");
        // R6: same line still pending at priority equal to cur_prio
        repeat (6) tick();
        chk(cpu_irq == 1'b0, "R6 equal priority offered", cpu_irq, 0);
        // R11: acknowledge without an offer
        cpu_ack = 1'b1; tick(); cpu_ack = 1'b0; tick();
        chk(cur_prio == 4'd3, "R11 idle ack changed cur_prio", cur_prio, 3);
        chk(cpu_irq == 1'b0, "R11 idle ack raised irq", cpu_irq, 0);
        set_prio(7, 4);
        src_req[7] = 1'b1;
        ack_expect(7, 4, "R6 higher line7");

        // R4: highest priority wins
        do_reset();
        set_prio(2, 2); set_prio(9, 6); set_prio(12, 5);
        src_req[2] = 1'b1; src_req[9] = 1'b1; src_req[12] = 1'b1;
        repeat (3) tick();
        chk(cpu_vec == 4'd9, "R4 highest priority vector", cpu_vec, 9);
        ack_expect(9, 6, "R4 line9");

        // R5: tie goes to the lowest index
        do_reset();
        set_prio(11, 7); set_prio(3, 7);
        src_req[11] = 1'b1; src_req[3] = 1'b1;
        repeat (3) tick();
        chk(cpu_vec == 4'd3, "R5 tie lowest index", cpu_vec, 3);
        ack_expect(3, 7, "R5 line3");

        // R7/R8: withdrawn offer persists despite a more urgent arrival
        do_reset();
        set_prio(4, 2);
        src_req[4] = 1'b1;
        repeat (3) tick();
        chk(cpu_irq == 1'b1, "R8 offer raised", cpu_irq, 1);
        src_req[4] = 1'b0;
        set_prio(1, 9);
        src_req[1] = 1'b1;
        repeat (5) tick();
        chk(cpu_irq == 1'b1, "R7 offer dropped early", cpu_irq, 1);
        chk(cpu_vec == 4'd4, "R7 vector changed", cpu_vec, 4);
        ack_expect(4, 2, "R8 withdrawn line4");
        ack_expect(1, 9, "R7 line1 after");

        tick(); tick();
        chk(sb.size() == 0, "R4 scoreboard drained", sb.size(), 0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule